// File: doc/BRIEF.md
# Wake-on-LAN Magic Frame Detector

The detector watches a received Ethernet byte stream (one byte per beat, with frame-start and frame-end markers) and raises a one-cycle match pulse when it sees a wake-on-LAN magic frame. A magic frame carries, somewhere after its 14-byte header, a synchronisation run of 0xFF bytes. The run is followed at once by sixteen back-to-back copies of the station's 48-bit address. The destination address of the frame is checked separately. By default it must equal the station address. Either of two OR-ed accept enables opens the check to any destination.

Detection runs only while the block is in magic-frame mode. Software enters that mode through a mode bit. The mode is also entered when a pin-enable bit is set and an active-low power-good input drops. The two conditions are OR-ed. Leaving the mode aborts any search in progress. The frame check sequence is not examined, and no frame is stored.

Top module: `wol_magic_detect`

## Requirements
- R1: A frame whose payload holds a run of six 0xFF bytes followed at once by sixteen back-to-back copies of the station address yields a match.
- R2: With both accept enables at 0, the frame matches only if its first six bytes equal the station address. Bytes are taken in transmission order, and the first received byte is compared with station address bits [7:0].
- R3: With either accept enable at 1, any destination address qualifies (unicast, multicast or broadcast).
- R4: The accept enables relax only the destination check. A frame with fewer than sixteen correct copies in its payload does not match, whatever the enables are.
- R5: Setting the software mode bit enters magic-frame mode.
- R6: With the software bit at 0, the mode is entered when the pin enable is 1 and power-good is low. Power-good low alone, or the pin enable alone, leaves the detector idle.
- R7: The match pulse is only ever raised in magic-frame mode. It lasts exactly one cycle, starting in the cycle after the end-of-frame beat.
- R8: A synchronisation run longer than six 0xFF bytes is accepted, and the copies may follow straight after it. A run of only five 0xFF bytes does not start the copy search.
- R9: A wrong byte during the copies restarts the search. That byte is itself re-evaluated, so an 0xFF there counts as the first byte of a new run.
- R10: A frame that ends before all sixteen copies have been received does not match. A frame whose end-of-frame beat is the last address byte of the sixteenth copy does match.
- R11: Leaving magic-frame mode in the middle of a frame aborts the search, and that frame cannot match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| rx_data_i | input | 8 | Received byte |
| rx_valid_i | input | 1 | Byte valid this cycle |
| rx_sof_i | input | 1 | Byte is the first of a frame |
| rx_eof_i | input | 1 | Byte is the last of a frame |
| station_addr_i | input | 48 | Station address, bits [7:0] sent first |
| accept_any_a_i | input | 1 | First destination accept enable |
| accept_any_b_i | input | 1 | Second destination accept enable |
| sw_mode_i | input | 1 | Software magic-frame mode enable |
| pin_en_i | input | 1 | Enables mode entry from power-good |
| pwr_good_ni | input | 1 | Power-good, low means power lost |
| match_o | output | 1 | One-cycle magic frame match pulse |

## Verification
On every cycle, the assertions check the following properties of the match pulse: it is only raised after an end-of-frame beat in mode, it lasts one cycle, and it never fires without a qualifying destination. They also check that setting the software bit always brings the mode up, that leaving the mode clears the scanner, and that the copy search only starts after an 0xFF byte. Only the bench scenarios show the content-dependent results: the byte order of the address compare, long and short 0xFF runs, restart with re-evaluation of the failing byte, truncated frames, and the pin-driven mode entry through the power-good synchroniser.

// File: rtl/wol_pkg.sv
package wol_pkg;
  typedef logic [7:0] byte_t;
  localparam byte_t SYNC_BYTE = 8'hFF;
  localparam int unsigned DEF_ADDR_BYTES = 6;
  localparam int unsigned DEF_SYNC_LEN = 6;
  localparam int unsigned DEF_COPIES = 16;
endpackage

// File: rtl/wol_mode_ctrl.sv
module wol_mode_ctrl #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sw_mode_i,
  input  logic pin_en_i,
  input  logic pwr_good_ni,
  output logic mode_o
);
  logic [SYNC_STAGES-1:0] pg_sync_q;
  logic                   mode_q;

  // power-good is asynchronous; reset to "power good"
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pg_sync_q <= '1;
    else         pg_sync_q <= {pg_sync_q[SYNC_STAGES-2:0], pwr_good_ni};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mode_q <= 1'b0;
    else         mode_q <= sw_mode_i | (pin_en_i & ~pg_sync_q[SYNC_STAGES-1]);
  end

  assign mode_o = mode_q;

  AST_SW_ENTERS_MODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sw_mode_i |=> mode_o); // R5
endmodule

// File: rtl/wol_dest_check.sv
module wol_dest_check
  import wol_pkg::*;
#(
  parameter int unsigned ADDR_BYTES = DEF_ADDR_BYTES
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    beat_i,
  input  logic                    sof_i,
  input  byte_t                   byte_i,
  input  logic [ADDR_BYTES*8-1:0] addr_i,
  output logic                    done_o,
  output logic                    eq_o
);
  localparam int unsigned IDX_W = $clog2(ADDR_BYTES + 1);

  byte_t             addr_b [ADDR_BYTES];
  logic  [IDX_W-1:0] idx_q;
  logic              eq_q;

  for (genvar g = 0; g < ADDR_BYTES; g++) begin : g_unpack
    assign addr_b[g] = addr_i[g*8 +: 8];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q <= '0;
      eq_q  <= 1'b0;
    end else if (beat_i && sof_i) begin
      idx_q <= IDX_W'(1);
      eq_q  <= (byte_i == addr_b[0]);
    end else if (beat_i && idx_q < IDX_W'(ADDR_BYTES)) begin
      idx_q <= idx_q + IDX_W'(1);
      eq_q  <= eq_q & (byte_i == addr_b[idx_q]);
    end
  end

  assign done_o = (idx_q == IDX_W'(ADDR_BYTES));
  assign eq_o   = eq_q;

  AST_DA_DONE_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !(beat_i && sof_i)) |=> done_o); // R2
endmodule

// File: rtl/wol_payload_scan.sv
module wol_payload_scan
  import wol_pkg::*;
#(
  parameter int unsigned ADDR_BYTES = DEF_ADDR_BYTES,
  parameter int unsigned SYNC_LEN   = DEF_SYNC_LEN,
  parameter int unsigned COPIES     = DEF_COPIES
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    clear_i,
  input  logic                    byte_v_i,
  input  byte_t                   byte_i,
  input  logic [ADDR_BYTES*8-1:0] addr_i,
  output logic                    found_o,
  output logic                    hit_o
);
  localparam int unsigned RUN_W = $clog2(SYNC_LEN + 1);
  localparam int unsigned POS_W = $clog2(ADDR_BYTES);
  localparam int unsigned CNT_W = $clog2(COPIES);

  byte_t             addr_b [ADDR_BYTES];
  logic [RUN_W-1:0]  run_q, run_d;
  logic [POS_W-1:0]  pos_q, pos_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              in_rep_q, in_rep_d;
  logic              found_q, found_d;
  logic              byte_ok, last_pos, last_copy, is_sync, at_start;

  for (genvar g = 0; g < ADDR_BYTES; g++) begin : g_unpack
    assign addr_b[g] = addr_i[g*8 +: 8];
  end

  assign byte_ok   = (byte_i == addr_b[pos_q]);
  assign last_pos  = (pos_q == POS_W'(ADDR_BYTES - 1));
  assign last_copy = (cnt_q == CNT_W'(COPIES - 1));
  assign is_sync   = (byte_i == SYNC_BYTE);
  assign at_start  = (pos_q == '0) && (cnt_q == '0);
  assign hit_o     = byte_v_i & in_rep_q & byte_ok & last_pos & last_copy;

  always_comb begin
    run_d    = run_q;
    pos_d    = pos_q;
    cnt_d    = cnt_q;
    in_rep_d = in_rep_q;
    found_d  = found_q;
    if (clear_i) begin
      run_d    = '0;
      pos_d    = '0;
      cnt_d    = '0;
      in_rep_d = 1'b0;
      found_d  = 1'b0;
    end else if (byte_v_i && !found_q) begin
      if (in_rep_q) begin
        if (byte_ok) begin
          if (last_pos) begin
            pos_d = '0;
            if (last_copy) begin
              found_d  = 1'b1;
              in_rep_d = 1'b0;
            end else begin
              cnt_d = cnt_q + CNT_W'(1);
            end
          end else begin
            pos_d = pos_q + POS_W'(1);
          end
        end else if (at_start && is_sync) begin
          // sync run longer than needed: keep waiting for the first copy
          in_rep_d = 1'b1;
        end else begin
          // restart, and let this byte open a new run
          in_rep_d = 1'b0;
          pos_d    = '0;
          cnt_d    = '0;
          run_d    = is_sync ? RUN_W'(1) : '0;
        end
      end else if (is_sync) begin
        if (run_q == RUN_W'(SYNC_LEN - 1)) begin
          in_rep_d = 1'b1;
          run_d    = '0;
          pos_d    = '0;
          cnt_d    = '0;
        end else begin
          run_d = run_q + RUN_W'(1);
        end
      end else begin
        run_d = '0;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q    <= '0;
      pos_q    <= '0;
      cnt_q    <= '0;
      in_rep_q <= 1'b0;
      found_q  <= 1'b0;
    end else begin
      run_q    <= run_d;
      pos_q    <= pos_d;
      cnt_q    <= cnt_d;
      in_rep_q <= in_rep_d;
      found_q  <= found_d;
    end
  end

  assign found_o = found_q;

  AST_FOUND_AFTER_COPIES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(found_q) |-> $past(in_rep_q)); // R1
  AST_REP_AFTER_SYNC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(in_rep_q) |-> $past(byte_v_i && byte_i == SYNC_BYTE)); // R8
  AST_CLEAR_ABORTS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> (!found_q && !in_rep_q && run_q == '0)); // R11
endmodule

// File: rtl/wol_magic_detect.sv
module wol_magic_detect
  import wol_pkg::*;
#(
  parameter int unsigned ADDR_W      = 48,
  parameter int unsigned SYNC_LEN    = DEF_SYNC_LEN,
  parameter int unsigned COPIES      = DEF_COPIES,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [7:0]        rx_data_i,
  input  logic              rx_valid_i,
  input  logic              rx_sof_i,
  input  logic              rx_eof_i,
  input  logic [ADDR_W-1:0] station_addr_i,
  input  logic              accept_any_a_i,
  input  logic              accept_any_b_i,
  input  logic              sw_mode_i,
  input  logic              pin_en_i,
  input  logic              pwr_good_ni,
  output logic              match_o
);
  localparam int unsigned ADDR_BYTES = ADDR_W / 8;

  logic mode_q, frame_q, match_q;
  logic beat, sof_beat, eof_beat, payload_v, scan_clear;
  logic da_done, da_eq, found, hit, da_ok;

  wol_mode_ctrl #(.SYNC_STAGES(SYNC_STAGES)) i_mode (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sw_mode_i  (sw_mode_i),
    .pin_en_i   (pin_en_i),
    .pwr_good_ni(pwr_good_ni),
    .mode_o     (mode_q)
  );

  assign sof_beat   = rx_valid_i & rx_sof_i & mode_q;
  assign beat       = rx_valid_i & mode_q & (rx_sof_i | frame_q);
  assign eof_beat   = beat & rx_eof_i & ~rx_sof_i;
  assign payload_v  = beat & ~rx_sof_i & da_done;
  assign scan_clear = ~mode_q | (rx_valid_i & rx_sof_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      frame_q <= 1'b0;
    else if (!mode_q)                 frame_q <= 1'b0;
    else if (sof_beat)                frame_q <= ~rx_eof_i;
    else if (beat && rx_eof_i)        frame_q <= 1'b0;
  end

  wol_dest_check #(.ADDR_BYTES(ADDR_BYTES)) i_dest (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .beat_i(beat),
    .sof_i (rx_sof_i),
    .byte_i(rx_data_i),
    .addr_i(station_addr_i),
    .done_o(da_done),
    .eq_o  (da_eq)
  );

  wol_payload_scan #(
    .ADDR_BYTES(ADDR_BYTES),
    .SYNC_LEN  (SYNC_LEN),
    .COPIES    (COPIES)
  ) i_scan (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (scan_clear),
    .byte_v_i(payload_v),
    .byte_i  (rx_data_i),
    .addr_i  (station_addr_i),
    .found_o (found),
    .hit_o   (hit)
  );

  assign da_ok = da_eq | accept_any_a_i | accept_any_b_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) match_q <= 1'b0;
    else         match_q <= eof_beat & da_done & da_ok & (found | hit);
  end

  assign match_o = match_q;

  AST_MATCH_IN_MODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    match_o |-> $past(mode_q)); // R7
  AST_MATCH_AT_EOF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    match_o |-> $past(rx_valid_i && rx_eof_i)); // R7
  AST_MATCH_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    match_o |=> !match_o); // R7
  AST_MATCH_NEEDS_DA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    match_o |-> $past(da_eq || accept_any_a_i || accept_any_b_i)); // R2
endmodule

// File: tb/test_wol_magic_detect.sv
module test_wol_magic_detect;
  localparam logic [47:0] STA = 48'h0A1B2C3D4E5F;
  localparam logic [47:0] SRC = 48'h112233445566;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [7:0]  rx_data_i = '0;
  logic        rx_valid_i = 1'b0, rx_sof_i = 1'b0, rx_eof_i = 1'b0;
  logic        accept_any_a_i = 1'b0, accept_any_b_i = 1'b0;
  logic        sw_mode_i = 1'b1, pin_en_i = 1'b0, pwr_good_ni = 1'b1;
  logic        match_o;

  int n_tests = 0, n_fail = 0, pulses = 0;
  logic [7:0] fbuf [0:511];
  int flen = 0;
  logic first_after;

  always #10 clk_i = ~clk_i;

  wol_magic_detect i_wol_magic_detect (
    .clk_i, .rst_ni, .rx_data_i, .rx_valid_i, .rx_sof_i, .rx_eof_i,
    .station_addr_i(STA), .accept_any_a_i, .accept_any_b_i,
    .sw_mode_i, .pin_en_i, .pwr_good_ni, .match_o
  );

  always @(negedge clk_i) if (match_o) pulses++;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic push(input logic [7:0] b); fbuf[flen] = b; flen++; endtask
  task automatic push_addr(input logic [47:0] a);
    for (int k = 0; k < 6; k++) push(a[k*8 +: 8]);
  endtask
  task automatic push_ff(input int n); for (int k = 0; k < n; k++) push(8'hFF); endtask
  task automatic push_copies(input int n); for (int k = 0; k < n; k++) push_addr(STA); endtask
  task automatic start_frame(input logic [47:0] da);
    flen = 0; push_addr(da); push_addr(SRC); push(8'h08); push(8'h42);
  endtask

  // drop_at >= 0: leave magic-frame mode before that byte, then return
  task automatic send(input int drop_at);
    pulses = 0;
    for (int i = 0; i < flen; i++) begin
      @(negedge clk_i);
      if (i == drop_at) begin
        rx_valid_i = 1'b0; sw_mode_i = 1'b0;
        repeat (3) @(negedge clk_i);
        sw_mode_i = 1'b1;
        repeat (3) @(negedge clk_i);
      end
      rx_data_i = fbuf[i]; rx_valid_i = 1'b1;
      rx_sof_i = (i == 0); rx_eof_i = (i == flen - 1);
    end
    @(negedge clk_i);
    rx_valid_i = 1'b0; rx_sof_i = 1'b0; rx_eof_i = 1'b0;
    first_after = match_o;
    repeat (4) @(negedge clk_i);
  endtask

  task automatic run_expect(input string req, input int exp, input int drop_at);
    send(drop_at);
    check(pulses == exp, req, pulses, exp);
    check(int'(first_after) == exp, {req, " timing"}, int'(first_after), exp);
  endtask

  task automatic t_reset;
    check(match_o == 1'b0, "R7 reset", int'(match_o), 0);
  endtask

  task automatic t_basic;
    start_frame(STA); push(8'h00); push_ff(6); push_copies(16); push(8'h12); push(8'h34);
    run_expect("R1 basic", 1, -1);
    @(negedge clk_i);
    check(match_o == 1'b0, "R7 single pulse", int'(match_o), 0);
  endtask

  task automatic t_dest;
    start_frame(48'h0A1B2C3D4E50); push_ff(6); push_copies(16); push(8'h00);
    run_expect("R2 wrong DA", 0, -1);
    start_frame(48'h5F4E3D2C1B0A); push_ff(6); push_copies(16); push(8'h00);
    run_expect("R2 byte order", 0, -1);
    accept_any_a_i = 1'b1;
    start_frame(48'hFFFFFFFFFFFF); push_ff(6); push_copies(16); push(8'h00);
    run_expect("R3 broadcast via a", 1, -1);
    accept_any_a_i = 1'b0; accept_any_b_i = 1'b1;
    start_frame(48'h0000005E0001); push_ff(6); push_copies(16); push(8'h00);
    run_expect("R3 multicast via b", 1, -1);
    accept_any_b_i = 1'b0;
  endtask

  task automatic t_payload_strict;
    accept_any_a_i = 1'b1; accept_any_b_i = 1'b1;
    start_frame(STA); push_ff(6); push_copies(15); push(8'h77); push_addr(STA); push(8'h00);
    run_expect("R4 broken copy", 0, -1);
    accept_any_a_i = 1'b0; accept_any_b_i = 1'b0;
  endtask

  task automatic t_sync_len;
    start_frame(STA); push_ff(10); push_copies(16); push(8'h00);
    run_expect("R8 long run", 1, -1);
    start_frame(STA); push(8'h01); push_ff(5); push_copies(16); push(8'h00);
    run_expect("R8 short run", 0, -1);
  endtask

  task automatic t_restart;
    start_frame(STA); push_ff(6); push_copies(3); push(8'h5F); push(8'h4E);
    push_ff(6); push_copies(16); push(8'h00);
    run_expect("R9 restart reevaluate", 1, -1);
  endtask

  task automatic t_truncated;
    start_frame(STA); push_ff(6); push_copies(15);
    run_expect("R10 truncated", 0, -1);
    start_frame(STA); push_ff(6); push_copies(16);
    run_expect("R10 eof on last byte", 1, -1);
  endtask

  task automatic t_modes;
    sw_mode_i = 1'b0; repeat (6) @(negedge clk_i);
    start_frame(STA); push_ff(6); push_copies(16); push(8'h00);
    run_expect("R5 mode off", 0, -1);
    pin_en_i = 1'b1; repeat (6) @(negedge clk_i);
    run_expect("R6 pin only", 0, -1);
    pwr_good_ni = 1'b0; repeat (6) @(negedge clk_i);
    run_expect("R6 pin and power low", 1, -1);
    pin_en_i = 1'b0; repeat (6) @(negedge clk_i);
    run_expect("R6 power low only", 0, -1);
    pwr_good_ni = 1'b1; sw_mode_i = 1'b1; repeat (6) @(negedge clk_i);
    run_expect("R5 sw mode", 1, -1);
  endtask

  task automatic t_abort;
    start_frame(STA); push_ff(6); push_copies(16); push(8'h00);
    run_expect("R11 abort mid frame", 0, 40);
    run_expect("R11 next frame ok", 1, -1);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk_i);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    repeat (6) @(negedge clk_i);
    t_reset();
    t_basic();
    t_dest();
    t_payload_strict();
    t_sync_len();
    t_restart();
    t_truncated();
    t_modes();
    t_abort();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule